// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a bit clock, a word clock and one serial data line from an external audio source and turns the stream into parallel samples. The three inputs may be asynchronous to the system clock. Each one passes through a synchronizer of the same depth, so the three stay aligned in time. Capture points are then found from edges of the synchronized bit clock.

Six framing schemes are supported. Four carry two channels: I2S, left-justified, right-justified and DSP frame-sync. Two are packed schemes that carry six channels in one frame. The format code and the word length are static inputs, changed only while reset is held. Every received word comes out left-aligned in 24 bits, together with a channel index and a one-cycle valid strobe.

Top module: `audio_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, `smp_valid` is 0, `smp_data` is 0 and `smp_chan` is 0.
- R2: Format code 0 (I2S) captures on bit clock rising edges with 32 bit clocks per half-frame. A low word clock marks channel 0 and a high word clock marks channel 1. The MSB is taken one bit clock after the word clock changes.
- R3: Format code 1 (left-justified) uses a high word clock for channel 0 and a low word clock for channel 1. The MSB is taken on the same rising edge at which the new word clock level is first seen.
- R4: Format code 2 (right-justified) uses the same word clock polarity as code 1. The LSB is the bit taken on the last rising bit clock edge before the word clock changes, at half-frame position 31.
- R5: Format code 3 (DSP) captures on bit clock falling edges. A word starts when the word clock is seen rising, and the MSB is taken on the next falling edge. Falling word clock edges do not restart a word. Channel indices alternate 0, 1, 0, … starting from 0 after reset.
- R6: Format code 4 (packed, 256 bit clocks per frame) is split into eight 32-clock slots. A low word clock marks the left half and a high word clock marks the right half. Slots 0–2 carry channels 0–2, slot 3 is empty, slots 4–6 carry channels 3–5 and slot 7 is empty. The MSB comes one bit clock after each slot starts.
- R7: Format code 5 (packed, 128 bit clocks per frame) uses a high word clock for the left half. Each 64-clock half holds three 20-clock slots followed by a 4-clock gap, giving channels 0–2 on the left and 3–5 on the right. The MSB is at the first clock of each slot. A 24-bit setting is treated as 20 bits in this format.
- R8: `wlen_sel` encodes the word length: 0 is 24 bits, 1 is 20 bits, 2 is 16 bits and 3 is 24 bits. The word appears in the top bits of `smp_data`, MSB first, with zeros below its LSB.
- R9: `smp_valid` is high for exactly one cycle per word. `smp_chan` never exceeds 5, and it is 0 or 1 in format codes 0–3.
- R10: In the packed formats, a word clock edge that opens the left half restarts the frame at slot 0, whatever the slot count is. An edge that opens the right half moves the count to the first right slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| wclk_in | input | 1 | Word clock / frame sync, asynchronous |
| sdin | input | 1 | Serial data line |
| fmt_sel | input | 3 | Format code (0–5) |
| wlen_sel | input | 2 | Word length code |
| smp_data | output | 24 | Received word, left-aligned |
| smp_chan | output | 3 | Channel index of the word |
| smp_valid | output | 1 | One-cycle strobe for a new word |

## Verification
Two events can fall on the same capture edge: the word clock change that restarts the position count, and a data bit that must be shifted in. In left-justified and 128-slot packed framing, that bit is the MSB. In the packed resync case, the restart lands partway through a frame. The bench sends back-to-back frames with random words whose MSBs are often set, and it cuts a 256-slot frame short just after slot 4. Each case is judged by comparing every emitted word and channel index against values built from the frame layout alone. A restart that is late by one bit, or a lost MSB, changes the value or the channel.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int WB_W     = $clog2(SAMPLE_W + 1);
  localparam int POS_W    = 8;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_LJ    = 3'd1,
    FMT_RJ    = 3'd2,
    FMT_DSP   = 3'd3,
    FMT_PK256 = 3'd4,
    FMT_PK128 = 3'd5
  } fmt_e;

  function automatic logic [WB_W-1:0] word_bits(input logic [1:0] wl, input logic pk128);
    logic [WB_W-1:0] n;
    case (wl)
      2'd1:    n = WB_W'(20);
      2'd2:    n = WB_W'(16);
      default: n = WB_W'(24);
    endcase
    if (pk128 && n > WB_W'(20)) n = WB_W'(20);
    return n;
  endfunction
endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/audio_rx_framer.sv
module audio_rx_framer
  import audio_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  fmt_e            fmt,
  input  logic [WB_W-1:0] wbits,
  input  logic            cap,
  input  logic            wclk,
  output logic            emit,
  output logic [2:0]      emit_ch
);
  logic             wclk_last;
  logic [POS_W-1:0] pos, pos_next, wb_pos;
  logic             armed, dsp_ch;
  logic             toggle, seen_edge, is_pk, left_lvl, half, cond;
  logic [1:0]       slot;
  logic [5:0]       off, loc;

  assign wb_pos   = POS_W'(wbits);
  assign toggle   = (wclk != wclk_last);
  assign is_pk    = (fmt == FMT_PK256) || (fmt == FMT_PK128);
  assign left_lvl = (fmt == FMT_PK128);

  always_comb begin
    seen_edge = (fmt == FMT_DSP) ? (toggle && wclk) : toggle;
    if (is_pk) begin
      if (toggle)
        pos_next = (wclk == left_lvl) ? '0 :
                   ((fmt == FMT_PK256) ? POS_W'(128) : POS_W'(64));
      else if (fmt == FMT_PK256)
        pos_next = pos + 1'b1;
      else
        pos_next = {1'b0, pos[6:0] + 7'd1};
    end else if (seen_edge) begin
      pos_next = '0;
    end else begin
      pos_next = (pos == '1) ? pos : pos + 1'b1;
    end
  end

  // slot decode for packed formats
  always_comb begin
    loc = pos_next[5:0];
    if (fmt == FMT_PK256) begin
      half = pos_next[7];
      slot = pos_next[6:5];
      off  = {1'b0, pos_next[4:0]};
    end else begin
      half = pos_next[6];
      if (loc < 6'd20)      begin slot = 2'd0; off = loc;          end
      else if (loc < 6'd40) begin slot = 2'd1; off = loc - 6'd20;  end
      else if (loc < 6'd60) begin slot = 2'd2; off = loc - 6'd40;  end
      else                  begin slot = 2'd3; off = loc - 6'd60;  end
    end
  end

  always_comb begin
    cond    = 1'b0;
    emit_ch = 3'd0;
    case (fmt)
      FMT_I2S:   begin cond = (pos_next == wb_pos);        emit_ch = {2'b0, wclk};  end
      FMT_LJ:    begin cond = (pos_next == wb_pos - 1'b1); emit_ch = {2'b0, ~wclk}; end
      FMT_RJ:    begin cond = (pos_next == POS_W'(31));    emit_ch = {2'b0, ~wclk}; end
      FMT_DSP:   begin cond = (pos_next == wb_pos);        emit_ch = {2'b0, dsp_ch}; end
      FMT_PK256: begin
        cond    = (slot != 2'd3) && (off == 6'(wbits));
        emit_ch = (half ? 3'd3 : 3'd0) + {1'b0, slot};
      end
      FMT_PK128: begin
        cond    = (slot != 2'd3) && (off == 6'(wbits) - 6'd1);
        emit_ch = (half ? 3'd3 : 3'd0) + {1'b0, slot};
      end
      default: ;
    endcase
  end

  assign emit = cap && (armed || seen_edge) && cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_last <= 1'b0;
      pos       <= '1;
      armed     <= 1'b0;
      dsp_ch    <= 1'b0;
    end else if (cap) begin
      wclk_last <= wclk;
      pos       <= pos_next;
      armed     <= armed | seen_edge;
      if (emit && fmt == FMT_DSP) dsp_ch <= ~dsp_ch;
    end
  end
endmodule

// File: rtl/audio_rx_shifter.sv
module audio_rx_shifter
  import audio_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cap,
  input  logic                bit_in,
  input  logic [WB_W-1:0]     wbits,
  input  logic                emit,
  input  logic [2:0]          emit_ch,
  output logic [SAMPLE_W-1:0] data,
  output logic [2:0]          chan,
  output logic                valid
);
  logic [SAMPLE_W-1:0] sreg, word_now, aligned;
  logic [WB_W-1:0]     pad;

  assign word_now = {sreg[SAMPLE_W-2:0], bit_in};
  assign pad      = WB_W'(SAMPLE_W) - wbits;
  assign aligned  = word_now << pad;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      data  <= '0;
      chan  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= emit;
      if (cap) sreg <= word_now;
      if (emit) begin
        data <= aligned;
        chan <= emit_ch;
      end
    end
  end
endmodule

// File: rtl/audio_rx.sv
module audio_rx
  import audio_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bclk_in,
  input  logic        wclk_in,
  input  logic        sdin,
  input  logic [2:0]  fmt_sel,
  input  logic [1:0]  wlen_sel,
  output logic [23:0] smp_data,
  output logic [2:0]  smp_chan,
  output logic        smp_valid
);
  logic [2:0]      synced;
  logic            bclk_q, cap, emit;
  logic [2:0]      emit_ch;
  logic [WB_W-1:0] wbits;
  fmt_e            fmt;

  assign fmt   = fmt_e'(fmt_sel);
  assign wbits = word_bits(wlen_sel, fmt == FMT_PK128);

  audio_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .din ({sdin, wclk_in, bclk_in}),
    .dout(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) bclk_q <= 1'b0;
    else     bclk_q <= synced[0];
  end

  assign cap = (fmt == FMT_DSP) ? (~synced[0] & bclk_q) : (synced[0] & ~bclk_q);

  audio_rx_framer i_framer (
    .clk    (clk),
    .rst    (rst),
    .fmt    (fmt),
    .wbits  (wbits),
    .cap    (cap),
    .wclk   (synced[1]),
    .emit   (emit),
    .emit_ch(emit_ch)
  );

  audio_rx_shifter i_shift (
    .clk    (clk),
    .rst    (rst),
    .cap    (cap),
    .bit_in (synced[2]),
    .wbits  (wbits),
    .emit   (emit),
    .emit_ch(emit_ch),
    .data   (smp_data),
    .chan   (smp_chan),
    .valid  (smp_valid)
  );
endmodule

// File: rtl/audio_rx_chk.sv
module audio_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  fmt_sel,
  input logic [1:0]  wlen_sel,
  input logic [23:0] smp_data,
  input logic [2:0]  smp_chan,
  input logic        smp_valid
);
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid); // R9
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> smp_chan <= 3'd5); // R9
  AST_TWO_CH_INDEX: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && fmt_sel <= 3'd3) |-> smp_chan <= 3'd1); // R9
  AST_PAD_SHORT16: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && wlen_sel == 2'd2) |-> smp_data[7:0] == 8'd0); // R8
  AST_PAD_PK128: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && fmt_sel == 3'd5) |-> smp_data[3:0] == 4'd0); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!smp_valid && smp_data == 24'd0)); // R1
endmodule

bind audio_rx audio_rx_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .fmt_sel  (fmt_sel),
  .wlen_sel (wlen_sel),
  .smp_data (smp_data),
  .smp_chan (smp_chan),
  .smp_valid(smp_valid)
);

// File: tb/test_audio_rx.sv
`timescale 1ns/1ps
module test_audio_rx;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bclk = 1'b0, wclk = 1'b0, sdin = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [1:0]  wlen = 2'd0;
  logic [23:0] smp_data;
  logic [2:0]  smp_chan;
  logic        smp_valid;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [23:0] got_d[$], exp_d[$];
  logic [2:0]  got_c[$], exp_c[$];
  logic [23:0] tx [6];
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  audio_rx i_audio_rx (
    .clk(clk), .rst(rst), .bclk_in(bclk), .wclk_in(wclk), .sdin(sdin),
    .fmt_sel(fmt), .wlen_sel(wlen),
    .smp_data(smp_data), .smp_chan(smp_chan), .smp_valid(smp_valid)
  );

  always @(negedge clk) begin
    if (!rst && smp_valid) begin
      got_d.push_back(smp_data);
      got_c.push_back(smp_chan);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int wbits_of(input int f, input int wl);
    int n;
    n = (wl == 1) ? 20 : (wl == 2) ? 16 : 24;
    if (f == 5 && n > 20) n = 20;
    return n;
  endfunction

  function automatic int flen(input int f);
    return (f == 4) ? 256 : (f == 5) ? 128 : 64;
  endfunction

  // returns {is_lsb, ch[2:0], wclk, data}; ch 7 = no data
  function automatic logic [5:0] bit_at(input int f, input int w, input int p);
    int half, o, ch, idx, slot, loc;
    logic wl;
    ch = 7; idx = -1; wl = 1'b0;
    half = p / 32; o = p % 32;
    case (f)
      0: begin wl = (half == 1); ch = half; idx = (o >= 1 && o <= w) ? w - o : -1; end
      1: begin wl = (half == 0); ch = half; idx = (o < w) ? w - 1 - o : -1; end
      2: begin wl = (half == 0); ch = half; idx = (o >= 32 - w) ? 31 - o : -1; end
      3: begin wl = (o == 0);    ch = half; idx = (o >= 1 && o <= w) ? w - o : -1; end
      4: begin
        slot = p / 32; wl = (slot >= 4);
        if (slot < 3) ch = slot; else if (slot > 3 && slot < 7) ch = slot - 1; else ch = 7;
        idx = (ch != 7 && o >= 1 && o <= w) ? w - o : -1;
      end
      default: begin
        half = p / 64; loc = p % 64; slot = loc / 20; o = loc % 20;
        wl = (half == 0);
        ch = (slot < 3) ? half * 3 + slot : 7;
        idx = (ch != 7 && o < w) ? w - 1 - o : -1;
      end
    endcase
    if (idx < 0) return {1'b0, 3'd7, wl, 1'b0};
    return {(idx == 0), 3'(ch), wl, tx[ch][idx]};
  endfunction

  task automatic drive_bit(input logic w, input logic d);
    if (fmt == 3'd3) begin
      bclk = 1'b1; wclk = w; sdin = d;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      bclk = 1'b0; wclk = w; sdin = d;
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_frame(input int f, input int w, input int nbits);
    logic [5:0] b;
    for (int i = 0; i < 6; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      tx[i] = lcg[31:8] & ((24'd1 << w) - 24'd1);
    end
    for (int p = 0; p < nbits; p++) begin
      b = bit_at(f, w, p);
      drive_bit(b[1], b[0]);
      if (b[5]) begin
        exp_d.push_back(tx[b[4:2]] << (24 - w));
        exp_c.push_back(b[4:2]);
      end
    end
  endtask

  task automatic start(input int f, input int wl);
    logic [5:0] b;
    rst = 1'b1; bclk = 1'b0; wclk = 1'b0; sdin = 1'b0;
    fmt = 3'(f); wlen = 2'(wl);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    got_d.delete(); got_c.delete(); exp_d.delete(); exp_c.delete();
    b = bit_at(f, wbits_of(f, wl), flen(f) - 1);
    for (int i = 0; i < 4; i++) drive_bit(b[1], 1'b0);
  endtask

  task automatic finish_case(input string req);
    int n;
    repeat (40) @(negedge clk);
    chk(got_d.size() == exp_d.size(), req, "word count", got_d.size(), exp_d.size());
    n = (got_d.size() < exp_d.size()) ? got_d.size() : exp_d.size();
    for (int i = 0; i < n; i++) begin
      chk(got_d[i] == exp_d[i], req, $sformatf("data[%0d]", i), got_d[i], exp_d[i]);
      chk(got_c[i] == exp_c[i], req, $sformatf("chan[%0d]", i), got_c[i], exp_c[i]);
    end
  endtask

  task automatic run_case(input int f, input int wl, input int frames, input string req);
    int w;
    w = wbits_of(f, wl);
    start(f, wl);
    for (int k = 0; k < frames; k++) send_frame(f, w, flen(f));
    finish_case(req);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(smp_valid == 1'b0, "R1", "valid in reset", smp_valid, 0);
    chk(smp_data == 24'd0, "R1", "data in reset", smp_data, 0);
    chk(smp_chan == 3'd0, "R1", "chan in reset", smp_chan, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(smp_valid == 1'b0 && smp_data == 24'd0, "R1", "after reset", smp_data, 0);
  endtask

  task automatic test_resync();
    start(4, 0);
    send_frame(4, 24, 160);   // cut short after slot 4: R10
    send_frame(4, 24, 256);
    finish_case("R10");
  endtask

  initial begin
    test_reset();
    run_case(0, 0, 3, "R2");
    run_case(0, 2, 2, "R2_R8");
    run_case(1, 1, 3, "R3_R8");
    run_case(1, 0, 2, "R3");
    run_case(2, 0, 3, "R4");
    run_case(2, 2, 2, "R4_R8");
    run_case(3, 0, 3, "R5");
    run_case(3, 1, 2, "R5_R8");
    run_case(4, 0, 2, "R6");
    run_case(4, 2, 2, "R6_R8");
    run_case(5, 1, 2, "R7");
    run_case(5, 0, 2, "R7_R8");
    run_case(0, 3, 2, "R8");
    test_resync();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule